// File: doc/BRIEF.md
# Character Cell Row Scanner with Cursor Overlay

This block refreshes a row of four 5 x 7 dot-matrix character cells, one row of dots at a time. A row counter steps through the seven dot rows. It moves on after a programmable number of clock cycles and wraps back to the top row. For every row it produces five column bits per digit.

For each digit, the column bits come from one of two sources. Normally they come from a built-in font lookup of the digit's stored 7-bit character code. When the global cursor enable is high and that digit's cursor bit is set, they come from a full-block cursor instead. The cursor lights all 35 dots, but only during the first half of each row period, so it appears at half brightness.

A per-digit blank input forces that digit's columns to zero. It does not disturb the scan. A frame-start pulse marks the first cycle of the top row.

All ports are plain level signals that are sampled or driven every cycle. There is no handshake. The character codes and cursor bits are read combinationally from the storage that holds them, so a change reaches the columns in the same cycle.

Top module: `char_scan_mux`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `row_sel` is 0 and `frame_start` is 1.
- R2: `row_sel` holds each value for `row_len` clock cycles, then steps 0,1,...,6 and back to 0. A `row_len` below 2 is treated as 2.
- R3: `frame_start` is 1 only on the first cycle of row 0, and is never high on two consecutive cycles.
- R4: A non-cursor, unblanked digit shows its font glyph. Column bit 4 is the leftmost column, and row 0 is the top row. The glyphs are:
  - code 0x41: 01110,10001,10001,11111,10001,10001,10001
  - code 0x48: 10001,10001,10001,11111,10001,10001,10001
  - code 0x31: 00100,01100,00100,00100,00100,00100,01110
  - code 0x20: all zero
- R5: When `cursor_en` is 1 and `cursor_bits[d]` is 1, `cursor_on[d]` is 1. In the first half of the row period (phase below `row_len/2`, rounded down) that digit shows 11111.
- R6: A cursor digit shows 00000 in the second half of each row period (phase at or above `row_len/2`). Glyph digits are the same in both halves.
- R7: When `cursor_en` is 0, every digit shows its glyph and every `cursor_on` bit is 0, whatever the cursor bits hold. A digit whose cursor bit is 0 is never a cursor digit.
- R8: When `digit_blank[d]` is 1, the columns of digit d are 00000, for glyph and cursor alike. The row sequence is unaffected.
- R9: Any code not listed in R4 shows an outline box: 11111 on rows 0 and 6, and 10001 on rows 1 to 5.
- R10: Digit d is taken from `char_codes[7d+6:7d]` and drives `col_data[5d+4:5d]`. Digit 0 is the rightmost character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_len | input | PER_W (8) | Clock cycles per row (minimum 2) |
| char_codes | input | DIGITS*7 (28) | Stored character codes, digit 0 in the low bits |
| cursor_bits | input | DIGITS (4) | Per-digit cursor bits |
| cursor_en | input | 1 | Global cursor enable |
| digit_blank | input | DIGITS (4) | Per-digit blank |
| row_sel | output | 3 | Current dot row, 0 is the top |
| col_data | output | DIGITS*5 (20) | Column bits per digit, bit 4 of each digit is the leftmost |
| cursor_on | output | DIGITS (4) | Half-intensity cursor qualifier per digit |
| frame_start | output | 1 | High on the first cycle of row 0 |

## Verification
Blanking and the cursor's half-period suppression can act on the same digit in the same cycle. The bench provokes this by setting blank on a cursor digit and then sampling it in both halves of a row. Zero columns are expected in both halves, while `cursor_on` stays set. The row wrap and the frame pulse can also coincide with a cursor digit entering its dark half. The bench judges this by counting cycles from an observed frame start and checking `row_sel` and the columns at exact phase offsets.

// File: rtl/char_scan_pkg.sv
package char_scan_pkg;
  localparam int CODE_W   = 7;
  localparam int CELL_COLS = 5;
  localparam int CELL_ROWS = 7;
  localparam int ROW_W    = $clog2(CELL_ROWS);

  typedef logic [CELL_COLS-1:0] colbits_t;
  typedef logic [CODE_W-1:0]    code_t;
  typedef logic [ROW_W-1:0]     row_t;

  // Font subset; bit 4 is the leftmost column, row 0 is the top row.
  function automatic colbits_t glyph_row(input code_t code, input row_t row);
    colbits_t r;
    case (code)
      7'h20: r = '0;
      7'h41: begin
        case (row)
          3'd0:    r = 5'b01110;
          3'd3:    r = 5'b11111;
          default: r = 5'b10001;
        endcase
      end
      7'h48: begin
        r = (row == 3'd3) ? 5'b11111 : 5'b10001;
      end
      7'h31: begin
        case (row)
          3'd1:    r = 5'b01100;
          3'd6:    r = 5'b01110;
          default: r = 5'b00100;
        endcase
      end
      default: begin
        r = (row == 3'd0 || row == 3'd6) ? 5'b11111 : 5'b10001;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/char_scan_timer.sv
module char_scan_timer
  import char_scan_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] row_len,
  output row_t             row,
  output logic             late_half,
  output logic             frame_start
);
  localparam row_t LAST_ROW = row_t'(CELL_ROWS - 1);
  localparam logic [PER_W-1:0] MIN_LEN = PER_W'(2);

  logic [PER_W-1:0] phase;
  logic [PER_W-1:0] eff_len;
  logic             row_end;

  assign eff_len = (row_len < MIN_LEN) ? MIN_LEN : row_len;
  assign row_end = (phase >= eff_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      row   <= '0;
    end else if (row_end) begin
      phase <= '0;
      row   <= (row == LAST_ROW) ? '0 : row + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign late_half   = (phase >= (eff_len >> 1));
  assign frame_start = (row == '0) && (phase == '0);

  // R2: row never leaves the seven-row range
  p_row_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    row <= LAST_ROW);

  // R2: row only steps forward by one or wraps from the last row
  p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row != $past(row)) |->
      ((row == row_t'($past(row) + 1'b1)) || (row == '0 && $past(row) == LAST_ROW)));

  // R3: frame pulse lasts one cycle
  p_frame_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: rtl/char_scan_glyph.sv
module char_scan_glyph
  import char_scan_pkg::*;
(
  input  code_t    code,
  input  row_t     row,
  output colbits_t cols
);
  assign cols = glyph_row(code, row);
endmodule

// File: rtl/char_scan_cell.sv
module char_scan_cell
  import char_scan_pkg::*;
(
  input  colbits_t glyph,
  input  logic     cur_en,
  input  logic     cur_bit,
  input  logic     blank,
  input  logic     late_half,
  output colbits_t cols,
  output logic     cursor_on
);
  colbits_t cursor_pat;

  assign cursor_on  = cur_en & cur_bit;
  assign cursor_pat = late_half ? '0 : '1;

  always_comb begin
    if (blank)          cols = '0;
    else if (cursor_on) cols = cursor_pat;
    else                cols = glyph;
  end
endmodule

// File: rtl/char_scan_mux.sv
module char_scan_mux
  import char_scan_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int PER_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PER_W-1:0]          row_len,
  input  logic [DIGITS*CODE_W-1:0]  char_codes,
  input  logic [DIGITS-1:0]         cursor_bits,
  input  logic                      cursor_en,
  input  logic [DIGITS-1:0]         digit_blank,
  output logic [ROW_W-1:0]          row_sel,
  output logic [DIGITS*CELL_COLS-1:0] col_data,
  output logic [DIGITS-1:0]         cursor_on,
  output logic                      frame_start
);
  row_t row;
  logic late_half;

  char_scan_timer #(.PER_W(PER_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_len     (row_len),
    .row         (row),
    .late_half   (late_half),
    .frame_start (frame_start)
  );

  assign row_sel = row;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    colbits_t glyph;
    colbits_t cols;
    logic     cur;

    char_scan_glyph u_glyph (
      .code (char_codes[d*CODE_W +: CODE_W]),
      .row  (row),
      .cols (glyph)
    );

    char_scan_cell u_cell (
      .glyph     (glyph),
      .cur_en    (cursor_en),
      .cur_bit   (cursor_bits[d]),
      .blank     (digit_blank[d]),
      .late_half (late_half),
      .cols      (cols),
      .cursor_on (cur)
    );

    assign col_data[d*CELL_COLS +: CELL_COLS] = cols;
    assign cursor_on[d] = cur;

    // R8: a blanked digit drives nothing
    p_blank_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      digit_blank[d] |-> (cols == '0));

    // R5: unblanked cursor digit is fully lit in the first half
    p_cursor_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur && !late_half && !digit_blank[d]) |-> (cols == '1));

    // R6: cursor digit is dark in the second half
    p_cursor_dim_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur && late_half) |-> (cols == '0));

    // R7: no cursor without the global enable
    p_cursor_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cursor_en |-> !cur);
  end
endmodule

// File: tb/char_scan_mux_test.sv
module char_scan_mux_test;
  localparam int DIGITS = 4;
  localparam int PER_W  = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [PER_W-1:0]     row_len = 8'd8;
  logic [DIGITS*7-1:0]  char_codes = {DIGITS{7'h20}};
  logic [DIGITS-1:0]    cursor_bits = '0;
  logic                 cursor_en = 1'b0;
  logic [DIGITS-1:0]    digit_blank = '0;
  logic [2:0]           row_sel;
  logic [DIGITS*5-1:0]  col_data;
  logic [DIGITS-1:0]    cursor_on;
  logic                 frame_start;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  char_scan_mux #(.DIGITS(DIGITS), .PER_W(PER_W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_len     (row_len),
    .char_codes  (char_codes),
    .cursor_bits (cursor_bits),
    .cursor_en   (cursor_en),
    .digit_blank (digit_blank),
    .row_sel     (row_sel),
    .col_data    (col_data),
    .cursor_on   (cursor_on),
    .frame_start (frame_start)
  );

  // code, cursor_en, cursor bit, blank, digit, row, half, expected columns
  localparam logic [20:0] VEC [14] = '{
    {7'h41, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 5'b01110},
    {7'h41, 1'b0, 1'b0, 1'b0, 2'd1, 3'd3, 1'b1, 5'b11111},
    {7'h48, 1'b0, 1'b0, 1'b0, 2'd2, 3'd1, 1'b0, 5'b10001},
    {7'h31, 1'b0, 1'b0, 1'b0, 2'd3, 3'd6, 1'b0, 5'b01110},
    {7'h20, 1'b0, 1'b0, 1'b0, 2'd0, 3'd2, 1'b0, 5'b00000},
    {7'h55, 1'b0, 1'b0, 1'b0, 2'd1, 3'd0, 1'b0, 5'b11111},
    {7'h55, 1'b0, 1'b0, 1'b0, 2'd1, 3'd4, 1'b1, 5'b10001},
    {7'h48, 1'b1, 1'b1, 1'b0, 2'd0, 3'd1, 1'b0, 5'b11111},
    {7'h48, 1'b1, 1'b1, 1'b0, 2'd0, 3'd1, 1'b1, 5'b00000},
    {7'h31, 1'b0, 1'b1, 1'b0, 2'd2, 3'd0, 1'b0, 5'b00100},
    {7'h31, 1'b1, 1'b0, 1'b0, 2'd2, 3'd0, 1'b1, 5'b00100},
    {7'h41, 1'b1, 1'b1, 1'b1, 2'd3, 3'd3, 1'b0, 5'b00000},
    {7'h41, 1'b1, 1'b1, 1'b1, 2'd3, 3'd3, 1'b1, 5'b00000},
    {7'h41, 1'b0, 1'b0, 1'b1, 2'd0, 3'd6, 1'b0, 5'b00000}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_frame();
    @(negedge clk);
    while (!frame_start) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 row in reset", int'(row_sel), 0);
    check("R1 frame in reset", int'(frame_start), 1);
    check("R1 columns of spaces", int'(col_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 row after release", int'(row_sel), 0);

    // Vector table, row period 8: first half phases 0..3, second 4..7
    for (int i = 0; i < 14; i++) begin
      logic [20:0] v;
      int dig, r, h, ce, cb, bl;
      string req;
      v   = VEC[i];
      ce  = int'(v[13]);
      cb  = int'(v[12]);
      bl  = int'(v[11]);
      dig = int'(v[10:9]);
      r   = int'(v[8:6]);
      h   = int'(v[5]);
      char_codes = {DIGITS{7'h20}};
      char_codes[dig*7 +: 7] = v[20:14];
      cursor_en   = v[13];
      cursor_bits = DIGITS'(cb) << dig;
      digit_blank = DIGITS'(bl) << dig;
      if (bl != 0)                   req = "R8";
      else if (ce != 0 && cb != 0)   req = (h != 0) ? "R6" : "R5";
      else if (ce != 0 || cb != 0)   req = "R7";
      else if (v[20:14] == 7'h55)    req = "R9";
      else if (dig != 0)             req = "R10";
      else                           req = "R4";
      wait_frame();
      repeat (r*8 + h*4) @(negedge clk);
      check("R2 row position", int'(row_sel), r);
      check(req, int'(col_data[dig*5 +: 5]), int'(v[4:0]));
      check("R5 cursor flag", int'(cursor_on[dig]), ce & cb);
    end

    // R8: blanking everything leaves the scan intact
    char_codes = {DIGITS{7'h41}};
    cursor_en = 1'b1;
    cursor_bits = 4'b0101;
    digit_blank = '1;
    wait_frame();
    repeat (8) @(negedge clk);
    check("R8 scan under blank", int'(row_sel), 1);
    check("R8 all dark", int'(col_data), 0);
    digit_blank = '0;
    @(negedge clk);
    check("R10 mixed digits row1 phase1", int'(col_data),
          int'({5'b10001, 5'b11111, 5'b10001, 5'b11111}));

    // R2/R3: row period 3, full frame plus wrap
    cursor_en = 1'b0;
    cursor_bits = '0;
    row_len = 8'd3;
    wait_frame();
    for (int k = 0; k < 24; k++) begin
      check("R2 row sequence", int'(row_sel), (k / 3) % 7);
      check("R3 frame pulse", int'(frame_start), ((k % 21) == 0) ? 1 : 0);
      @(negedge clk);
    end

    // R2: period below minimum is treated as 2
    row_len = 8'd0;
    wait_frame();
    @(negedge clk);
    check("R2 clamp hold", int'(row_sel), 0);
    @(negedge clk);
    check("R2 clamp step", int'(row_sel), 1);

    // R6: odd period 5, dark half starts at phase 2
    row_len = 8'd5;
    cursor_en = 1'b1;
    cursor_bits = 4'b0001;
    wait_frame();
    @(negedge clk);
    check("R5 odd period phase1", int'(col_data[4:0]), 5'h1f);
    @(negedge clk);
    check("R6 odd period phase2", int'(col_data[4:0]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule